// File: doc/BRIEF.md
# Phase-Two Synchronised DMA Bus Grant Arbiter

This block sits between an external DMA controller and a processor that share one bus. The controller raises a request line at any time. The arbiter samples that line on the processor's phase-two clock. It then raises a busy line toward the processor, which asks the processor to finish its current bus access and stop using the bus.

On the next phase-two edge the arbiter hands the bus to the controller with a grant. It does this only when the processor's input strobe and output strobe are both inactive, which means no bus access is under way. If either strobe is active, the arbiter keeps waiting and tries again on every later edge.

The grant stays up until the controller drops its request. Busy and grant then fall together. The arbiter spends one edge in a release state and one edge in idle before it will accept a new request. Address and count logic of the DMA engine is not part of this block.

Top module: `dma_grant_arbiter`

## Requirements
- R1: The request input passes through SYNC_STAGES phase-two flops (default 1). From idle, busy rises on the edge after the last flop first holds 1. With the default depth, that is the second edge at which the request is seen high.
- R2: Grant rises on the edge after busy rises, provided both processor strobes are low at that edge.
- R3: If either processor strobe is high at the planned grant edge, the arbiter keeps busy high and grant low. It retries on every later edge until both strobes are low.
- R4: The grant output is low in any cycle in which either processor strobe is high, whatever the internal state.
- R5: Busy and grant stay high for as long as the synchronised request stays high.
- R6: Once the synchronised request is low, busy and grant fall together on the next edge.
- R7: After a release the arbiter spends exactly one edge in release and one edge in idle. A request seen during release is ignored. Busy rises again no earlier than the second edge after outputs fall.
- R8: If the synchronised request falls while busy is high but before grant, busy falls on the next edge and grant never rises.
- R9: The active-low reset is asynchronous and drives busy and grant low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkPh2 | input | 1 | Processor phase-two clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| dmaReq | input | 1 | Request from the external controller; may be asynchronous |
| cpuReadStb | input | 1 | Processor input strobe; high while a read access is in progress |
| cpuWriteStb | input | 1 | Processor output strobe; high while a write access is in progress |
| busReqOut | output | 1 | Busy line to the processor asking it to give up the bus |
| busGrantOut | output | 1 | Bus grant to the external controller |

## Verification
The bench drives read and write strobes across the planned grant edge. A design that grants without checking them would hand over a bus still in use, and one that gives up instead of retrying would never grant. It raises a new request during the release edge: an arbiter without the idle gap would raise busy one edge too early. It drops the request while still waiting for the grant, where a faulty design would leave busy stuck high or grant anyway. It also pulses a strobe during the grant to catch a grant output that is not gated combinationally.

// File: rtl/dma_grant_pkg.sv
package dma_grant_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_REQ     = 2'd1,
    ST_GRANT   = 2'd2,
    ST_RELEASE = 2'd3
  } arbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic busyOn;
    logic grantOn;
  } ctrlStb_t;

endpackage

// File: rtl/dma_grant_sync.sv
module dma_grant_sync #(
  parameter int SYNC_STAGES = 1
) (
  input  logic clkPh2,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clkPh2 or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= asyncIn;
      end
    end else begin : g_multi
      always_ff @(posedge clkPh2 or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], asyncIn};
      end
    end
  endgenerate

  assign syncOut = chain[LAST];

endmodule

// File: rtl/dma_grant_path.sv
module dma_grant_path
  import dma_grant_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic     clkPh2,
  input  logic     rstN,
  input  logic     dmaReq,
  input  logic     cpuReadStb,
  input  logic     cpuWriteStb,
  input  ctrlStb_t ctrlStb,
  output logic     reqSync,
  output logic     accessActive,
  output logic     busReqOut,
  output logic     busGrantOut
);

  dma_grant_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clkPh2  (clkPh2),
    .rstN    (rstN),
    .asyncIn (dmaReq),
    .syncOut (reqSync)
  );

  assign accessActive = cpuReadStb | cpuWriteStb;
  assign busReqOut    = ctrlStb.busyOn;
  // final gate: never present a grant while the processor drives a strobe
  assign busGrantOut  = ctrlStb.grantOn & ~accessActive;

  // R4: a grant seen at the port is never concurrent with a strobe.
  a_r4_grant_gated: assert property (@(posedge clkPh2) disable iff (!rstN)
    busGrantOut |-> !(cpuReadStb || cpuWriteStb));

endmodule

// File: rtl/dma_grant_ctrl.sv
module dma_grant_ctrl
  import dma_grant_pkg::*;
(
  input  logic     clkPh2,
  input  logic     rstN,
  input  logic     reqSync,
  input  logic     accessActive,
  output ctrlStb_t ctrlStb
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (reqSync) stateNext = ST_REQ;
      ST_REQ: begin
        if (!reqSync)          stateNext = ST_RELEASE;
        else if (!accessActive) stateNext = ST_GRANT;
      end
      ST_GRANT:   if (!reqSync) stateNext = ST_RELEASE;
      ST_RELEASE: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clkPh2 or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ctrlStb.busyOn  = (state == ST_REQ) || (state == ST_GRANT);
  assign ctrlStb.grantOn = (state == ST_GRANT);

  // R1: busy only rises after the synchronised request was high.
  a_r1_busy_needs_req: assert property (@(posedge clkPh2) disable iff (!rstN)
    $rose(ctrlStb.busyOn) |-> $past(reqSync));

  // R2/R3: grant state is entered only when no access was in progress.
  a_r3_grant_bus_free: assert property (@(posedge clkPh2) disable iff (!rstN)
    $rose(ctrlStb.grantOn) |-> ($past(!accessActive) && $past(ctrlStb.busyOn)));

  // R6: grant and busy fall on the same edge.
  a_r6_drop_together: assert property (@(posedge clkPh2) disable iff (!rstN)
    $fell(ctrlStb.grantOn) |-> !ctrlStb.busyOn);

  // R7: release is always followed by idle, whatever the request does.
  a_r7_idle_gap: assert property (@(posedge clkPh2) disable iff (!rstN)
    (state == ST_RELEASE) |=> (state == ST_IDLE));

  // R5: grant holds while the synchronised request holds.
  a_r5_hold_grant: assert property (@(posedge clkPh2) disable iff (!rstN)
    (ctrlStb.grantOn && reqSync) |=> ctrlStb.grantOn);

endmodule

// File: rtl/dma_grant_arbiter.sv
module dma_grant_arbiter
  import dma_grant_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic clkPh2,
  input  logic rstN,
  input  logic dmaReq,
  input  logic cpuReadStb,
  input  logic cpuWriteStb,
  output logic busReqOut,
  output logic busGrantOut
);

  ctrlStb_t ctrlStb;
  logic     reqSync;
  logic     accessActive;

  dma_grant_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
    .clkPh2       (clkPh2),
    .rstN         (rstN),
    .dmaReq       (dmaReq),
    .cpuReadStb   (cpuReadStb),
    .cpuWriteStb  (cpuWriteStb),
    .ctrlStb      (ctrlStb),
    .reqSync      (reqSync),
    .accessActive (accessActive),
    .busReqOut    (busReqOut),
    .busGrantOut  (busGrantOut)
  );

  dma_grant_ctrl u_ctrl (
    .clkPh2       (clkPh2),
    .rstN         (rstN),
    .reqSync      (reqSync),
    .accessActive (accessActive),
    .ctrlStb      (ctrlStb)
  );

endmodule

// File: tb/sim_dma_grant_arbiter.sv
module sim_dma_grant_arbiter;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  busy;
    logic  grant;
    string tag;
  } expItem_t;

  logic clkPh2 = 1'b0;
  logic rstN   = 1'b0;
  logic dmaReq = 1'b0;
  logic cpuReadStb  = 1'b0;
  logic cpuWriteStb = 1'b0;
  logic busReqOut, busGrantOut;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  expItem_t expQ[$];

  dma_grant_arbiter u0 (
    .clkPh2      (clkPh2),
    .rstN        (rstN),
    .dmaReq      (dmaReq),
    .cpuReadStb  (cpuReadStb),
    .cpuWriteStb (cpuWriteStb),
    .busReqOut   (busReqOut),
    .busGrantOut (busGrantOut)
  );

  always #(CLK_PERIOD/2) clkPh2 = ~clkPh2;

  task automatic compare(input logic eb, input logic eg, input string tag);
    total++;
    if (busReqOut !== eb || busGrantOut !== eg) begin
      bad++;
      $display("FAIL %s: busy/grant actual=%b%b expected=%b%b at %0t",
               tag, busReqOut, busGrantOut, eb, eg, $time);
    end
  endtask

  // driver: set inputs before an edge, queue the outputs expected after it
  task automatic step(input logic rq, input logic rd, input logic wr,
                      input logic eb, input logic eg, input string tag);
    expItem_t it;
    @(negedge clkPh2);
    dmaReq = rq; cpuReadStb = rd; cpuWriteStb = wr;
    it.busy = eb; it.grant = eg; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: sample shortly after each edge
  initial begin
    forever begin
      @(posedge clkPh2);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        compare(it.busy, it.grant, it.tag);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clkPh2);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    #3;
    compare(1'b0, 1'b0, "R9 reset state");
    repeat (2) @(negedge clkPh2);
    rstN = 1'b1;

    // basic grant and release
    step(1,0,0, 0,0, "R1 captured only");
    step(1,0,0, 1,0, "R1 busy rises");
    step(1,0,0, 1,1, "R2 grant next edge");
    step(1,0,0, 1,1, "R5 grant held");
    step(0,0,0, 1,1, "R5 sync lag");
    step(0,0,0, 0,0, "R6 drop together");
    step(0,0,0, 0,0, "R7 idle");

    // strobes active at the planned grant edge
    step(1,0,0, 0,0, "R1 captured only");
    step(1,0,0, 1,0, "R1 busy rises");
    step(1,1,0, 1,0, "R3 read in progress");
    step(1,0,1, 1,0, "R3 write in progress");
    step(1,0,0, 1,1, "R3 retry grants");
    step(0,0,0, 1,1, "R5 sync lag");
    step(0,0,0, 0,0, "R6 drop together");
    step(0,0,0, 0,0, "R7 idle");

    // new request during release
    step(1,0,0, 0,0, "R1 captured only");
    step(1,0,0, 1,0, "R1 busy rises");
    step(1,0,0, 1,1, "R2 grant");
    step(0,0,0, 1,1, "R5 sync lag");
    step(1,0,0, 0,0, "R6 release while req returns");
    step(1,0,0, 0,0, "R7 request ignored in release");
    step(1,0,0, 1,0, "R7 accepted after idle");
    step(0,0,0, 1,1, "R2 grant after gap");
    step(0,0,0, 0,0, "R6 drop together");
    step(0,0,0, 0,0, "R7 idle");

    // withdrawal before grant
    step(1,0,0, 0,0, "R1 captured only");
    step(0,0,0, 1,0, "R1 busy from pulse");
    step(0,1,0, 0,0, "R8 withdraw drops busy");
    step(0,0,0, 0,0, "R8 no grant after withdraw");

    // strobe during grant gates the output
    step(1,0,0, 0,0, "R1 captured only");
    step(1,0,0, 1,0, "R1 busy rises");
    step(1,0,0, 1,1, "R2 grant");
    step(1,1,0, 1,0, "R4 grant gated by read");
    step(1,0,1, 1,0, "R4 grant gated by write");
    step(1,0,0, 1,1, "R4 grant restored");
    step(0,0,0, 1,1, "R5 sync lag");
    step(0,0,0, 0,0, "R6 drop together");
    step(0,0,0, 0,0, "R7 idle");

    // asynchronous reset while granted
    step(1,0,0, 0,0, "R1 captured only");
    step(1,0,0, 1,0, "R1 busy rises");
    step(1,0,0, 1,1, "R2 grant");
    @(negedge clkPh2);
    rstN = 1'b0;
    #1;
    compare(1'b0, 1'b0, "R9 async reset");

    repeat (3) @(negedge clkPh2);
    summary();
  end

endmodule